// File: doc/BRIEF.md
# Command/Response FIFO Status Engine

This block is the device end of a byte-wide command/response channel. A host pushes a command one byte at a time into a data FIFO register, kicks it off with a go bit in the status register, waits until the status says a response is ready, and then pops the response out through the same FIFO register. Flow control works only through status flags and a 16-bit burst count. The host polls the status register and moves as many bytes as the burst count allows before it looks again.

The engine reads the command length from the header as bytes arrive. Header bytes 2 to 5 hold the total length as a big-endian 32-bit number. That value decides when the engine stops asking for more bytes. A length outside the buffer's range is rejected. Execution is a stub: it waits a number of cycles set by the `execDelay` input and then offers the stored command bytes back, unchanged, as the response. A write of command-ready to the status register returns the engine to idle from any state.

Top module: `cmdrsp_fifo_engine`

## Requirements
- R1: After reset the status byte reads 0xC0, which is valid and command-ready, and the burst count reads DEPTH.
- R2: Registers are at byte offsets 0x18 (status), 0x19 (burst count low byte), 0x1A (burst count high byte) and 0x24 (FIFO). Read data appears on `regRdData` one cycle after the read strobe. Status bits are: 7 valid, 6 command-ready, 5 go (always reads 0), 4 data-available, 3 expect, 2 length-error, and bits 1:0 read 0.
- R3: The first FIFO byte sets expect. Expect stays set until the number of bytes written equals the big-endian length in header bytes 2..5, and it clears after that final byte.
- R4: The burst count gives how many FIFO bytes may be moved now. While receiving before the length is known, it is DEPTH minus the bytes written. Once the length is known, it is the length minus the bytes written. While a response is pending, it is the number of response bytes left. In every other state it is 0.
- R5: A length field below 10 or above DEPTH sets the length-error bit and clears expect. After that, FIFO writes and go are ignored until an abort.
- R6: Writing go (status bit 5) once the whole command is in starts execution. Valid then reads 0 for exactly execDelay+1 cycles, after which valid and data-available both read 1.
- R7: The response bytes equal the command bytes in order. Data-available clears after the last one is read. FIFO reads beyond the response return 0.
- R8: Writing command-ready (status bit 6) from any state aborts and restores the reset status and burst count. This includes an abort during execution.
- R9: Go written before the command is complete is ignored. FIFO writes after the command is complete are ignored.
- R10: Command-ready reads 1 only in the idle state, and the first FIFO byte clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Byte offset within the locality window |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Read data, valid the cycle after regRdEn |
| execDelay | input | DELAY_W | Stub execution latency in cycles (minus one) |

## Verification
The bench builds the engine with DEPTH=64, so a 64-byte command exercises a length that sits exactly on the acceptance limit, and a length of 70 crosses it. With that default the burst count covers its full range from 64 down to 0. The stub latency is driven at 0, 3 and 20. This covers the shortest execution window, a typical one, and one long enough to abort part-way through.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;

  localparam logic [7:0] FIFO_BYTE_W = 8'd8;

  typedef enum logic [2:0] {
    ST_READY, ST_RECV, ST_FULL, ST_EXEC, ST_RESP, ST_DONE, ST_ERR
  } engState_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STS, SEL_BLO, SEL_BHI, SEL_FIFO
  } rdSel_t;

  typedef struct packed {
    logic   capture;
    logic   pop;
    rdSel_t readSel;
  } strobe_t;

endpackage

// File: rtl/cmdrsp_ctrl.sv
module cmdrsp_ctrl
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DELAY_W = 8,
  parameter int ADDR_W  = 12,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  input  logic [DELAY_W-1:0] execDelay,
  output strobe_t            strb,
  output logic [PTR_W-1:0]   wrPtr,
  output logic [PTR_W-1:0]   rdPtr,
  output logic [7:0]         statusByte,
  output logic [15:0]        burstCount
);

  localparam logic [ADDR_W-1:0] STS_ADDR  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] BLO_ADDR  = ADDR_W'(12'h019);
  localparam logic [ADDR_W-1:0] BHI_ADDR  = ADDR_W'(12'h01A);
  localparam logic [ADDR_W-1:0] FIFO_ADDR = ADDR_W'(12'h024);
  localparam int MIN_LEN = 10;

  engState_t          st;
  logic [CNT_W-1:0]   wrCount, rdCount, cmdLen;
  logic [23:0]        lenAcc;
  logic               lenKnown;
  logic [DELAY_W-1:0] delayCnt;

  logic stsWr, fifoWr, fifoRd, abortReq, goReq, acceptWr, popRd;
  logic headerByte, lenBad;
  logic [31:0] newLen;

  always_comb begin
    stsWr      = regWrEn && (regAddr == STS_ADDR);
    fifoWr     = regWrEn && (regAddr == FIFO_ADDR);
    fifoRd     = regRdEn && (regAddr == FIFO_ADDR);
    abortReq   = stsWr && regWrData[6];
    goReq      = stsWr && regWrData[5] && !regWrData[6];
    acceptWr   = fifoWr && (st == ST_READY || st == ST_RECV);
    popRd      = fifoRd && (st == ST_RESP);
    headerByte = (wrCount >= CNT_W'(2)) && (wrCount <= CNT_W'(5));
    newLen     = {lenAcc, regWrData};
    lenBad     = (newLen < 32'(MIN_LEN)) || (newLen > 32'(DEPTH));
  end

  always_comb begin
    strb.capture = acceptWr;
    strb.pop     = popRd;
    strb.readSel = SEL_NONE;
    if (regRdEn) begin
      if (regAddr == STS_ADDR)       strb.readSel = SEL_STS;
      else if (regAddr == BLO_ADDR)  strb.readSel = SEL_BLO;
      else if (regAddr == BHI_ADDR)  strb.readSel = SEL_BHI;
      else if (regAddr == FIFO_ADDR) strb.readSel = SEL_FIFO;
    end
    wrPtr = wrCount[PTR_W-1:0];
    rdPtr = rdCount[PTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || abortReq) begin
      st       <= ST_READY;
      wrCount  <= '0;
      rdCount  <= '0;
      cmdLen   <= '0;
      lenAcc   <= '0;
      lenKnown <= 1'b0;
      delayCnt <= '0;
    end else begin
      case (st)
        ST_READY, ST_RECV: begin
          if (acceptWr) begin
            wrCount <= wrCount + CNT_W'(1);
            st      <= ST_RECV;
            if (headerByte) lenAcc <= newLen[23:0];
            if (wrCount == CNT_W'(5)) begin
              if (lenBad) st <= ST_ERR;
              else begin
                lenKnown <= 1'b1;
                cmdLen   <= newLen[CNT_W-1:0];
              end
            end
            if (lenKnown && (wrCount + CNT_W'(1)) == cmdLen) st <= ST_FULL;
          end
        end
        ST_FULL: begin
          if (goReq) begin
            st       <= ST_EXEC;
            delayCnt <= execDelay;
          end
        end
        ST_EXEC: begin
          if (delayCnt == '0) st <= ST_RESP;
          else delayCnt <= delayCnt - DELAY_W'(1);
        end
        ST_RESP: begin
          if (popRd) begin
            rdCount <= rdCount + CNT_W'(1);
            if ((rdCount + CNT_W'(1)) == cmdLen) st <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  logic valid, cmdReady, dataAvail, expectMore, lenErr;
  always_comb begin
    valid      = (st != ST_EXEC);
    cmdReady   = (st == ST_READY);
    dataAvail  = (st == ST_RESP);
    expectMore = (st == ST_RECV);
    lenErr     = (st == ST_ERR);
    statusByte = {valid, cmdReady, 1'b0, dataAvail, expectMore, lenErr, 2'b00};
    case (st)
      ST_READY: burstCount = 16'(DEPTH);
      ST_RECV:  burstCount = lenKnown ? 16'(cmdLen - wrCount) : 16'(CNT_W'(DEPTH) - wrCount);
      ST_RESP:  burstCount = 16'(cmdLen - rdCount);
      default:  burstCount = 16'd0;
    endcase
  end

  AST_EXPECT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (acceptWr && lenKnown && (wrCount + CNT_W'(1)) == cmdLen && !abortReq) |=> !statusByte[3]); // R3
  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    burstCount <= 16'(DEPTH)); // R4
  AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_ERR && !abortReq) |=> ($stable(wrCount) && statusByte[2])); // R5
  AST_GO_HIDES_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_FULL && goReq) |=> !statusByte[7]); // R6
  AST_LAST_POP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (popRd && (rdCount + CNT_W'(1)) == cmdLen && !abortReq) |=> !statusByte[4]); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (statusByte == 8'hC0 && burstCount == 16'(DEPTH))); // R8

endmodule

// File: rtl/cmdrsp_datapath.sv
module cmdrsp_datapath
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [7:0]       wrByte,
  input  logic [7:0]       statusByte,
  input  logic [15:0]      burstCount,
  output logic [7:0]       rdData
);

  logic [7:0] buffer [DEPTH];

  always_ff @(posedge clk) begin
    if (strb.capture) buffer[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else begin
      case (strb.readSel)
        SEL_STS:  rdData <= statusByte;
        SEL_BLO:  rdData <= burstCount[7:0];
        SEL_BHI:  rdData <= burstCount[15:8];
        SEL_FIFO: rdData <= strb.pop ? buffer[rdPtr] : 8'h00;
        default:  ;
      endcase
    end
  end

  AST_POP_ON_FIFO_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (strb.readSel == SEL_FIFO)); // R7
  AST_STATUS_GO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readSel == SEL_STS) |=> (rdData[5] == 1'b0 && rdData[1:0] == 2'b00)); // R2

endmodule

// File: rtl/cmdrsp_fifo_engine.sv
module cmdrsp_fifo_engine
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DELAY_W = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  input  logic [DELAY_W-1:0] execDelay
);

  localparam int PTR_W = $clog2(DEPTH);

  strobe_t          strb;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [7:0]       statusByte;
  logic [15:0]      burstCount;

  cmdrsp_ctrl #(.DEPTH(DEPTH), .DELAY_W(DELAY_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .execDelay(execDelay),
    .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .statusByte(statusByte), .burstCount(burstCount)
  );

  cmdrsp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrByte(regWrData), .statusByte(statusByte), .burstCount(burstCount),
    .rdData(regRdData)
  );

endmodule

// File: tb/cmdrsp_fifo_engine_bench.sv
module cmdrsp_fifo_engine_bench;

  localparam int DEPTH = 64;
  localparam logic [11:0] A_STS = 12'h018, A_BLO = 12'h019, A_BHI = 12'h01A, A_FIFO = 12'h024;

  logic clk = 0, rstN = 0, regWrEn = 0, regRdEn = 0;
  logic [11:0] regAddr = '0;
  logic [7:0] regWrData = '0, regRdData, execDelay = '0;

  always #2 clk = ~clk;

  cmdrsp_fifo_engine #(.DEPTH(DEPTH)) u_cmdrsp_fifo_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .execDelay(execDelay)
  );

  int checks = 0, fails = 0;

  // Behavioural model: 0 idle,1 receive,2 full,3 exec,4 response,5 done,6 error
  int mState = 0, mWr = 0, mLen = 0, mRd = 0;
  bit mLenKnown = 0;
  logic [31:0] mAcc = 0;
  logic [7:0] mBuf[$];

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {mState != 3, mState == 0, 1'b0, mState == 4, mState == 1, mState == 6, 2'b00};
  endfunction

  function automatic logic [15:0] expBurst();
    case (mState)
      0: return 16'(DEPTH);
      1: return mLenKnown ? 16'(mLen - mWr) : 16'(DEPTH - mWr);
      4: return 16'(mLen - mRd);
      default: return 16'd0;
    endcase
  endfunction

  task automatic doWr(input logic [11:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdRaw(input logic [11:0] a, output logic [7:0] v);
    regRdEn = 1; regAddr = a;
    @(posedge clk); @(negedge clk);
    v = regRdData;
    regRdEn = 0;
  endtask

  task automatic rdCheck(input logic [11:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rdRaw(a, v);
    check({8'h0, v}, {8'h0, exp}, tag);
  endtask

  task automatic checkModel(input string tag);
    logic [15:0] b;
    b = expBurst();
    rdCheck(A_STS, expStatus(), {tag, " status"});
    rdCheck(A_BLO, b[7:0], {tag, " burst lo R4"});
    rdCheck(A_BHI, b[15:8], {tag, " burst hi R4"});
  endtask

  task automatic resetModel();
    mState = 0; mWr = 0; mLen = 0; mRd = 0; mLenKnown = 0; mAcc = 0;
    mBuf.delete();
  endtask

  task automatic pushByte(input logic [7:0] b);
    doWr(A_FIFO, b);
    if (mState == 0 || mState == 1) begin
      mState = 1;
      mBuf.push_back(b);
      if (mWr >= 2 && mWr <= 5) mAcc = {mAcc[23:0], b};
      if (mWr == 5) begin
        if (mAcc < 10 || mAcc > DEPTH) mState = 6;
        else begin mLenKnown = 1; mLen = int'(mAcc); end
      end
      mWr++;
      if (mLenKnown && mWr == mLen) mState = 2;
    end
  endtask

  task automatic abortCmd(input string tag);
    doWr(A_STS, 8'h40);
    resetModel();
    checkModel(tag);
  endtask

  function automatic logic [7:0] cmdByte(input int i, input int len, input int seed);
    logic [31:0] l;
    l = 32'(len);
    case (i)
      0: return 8'h80;
      1: return 8'hC1;
      2: return l[31:24];
      3: return l[23:16];
      4: return l[15:8];
      5: return l[7:0];
      default: return 8'(seed + i * 7);
    endcase
  endfunction

  task automatic goAndWait(input logic [7:0] dly, input string tag);
    logic [7:0] v;
    int n;
    execDelay = dly;
    doWr(A_STS, 8'h20);
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rdRaw(A_STS, v);
      if (v[7]) break;
      n++;
    end
    check(16'(n), 16'(dly) + 16'd1, {tag, " R6 valid-low cycles"});
    mState = 4;
    check({8'h0, v}, 16'h0090, {tag, " R6 ready status"});
  endtask

  task automatic readResp(input string tag);
    for (int i = 0; i < mLen; i++) begin
      rdCheck(A_FIFO, mBuf[i], {tag, " R7 response byte"});
      mRd++;
    end
    mState = 5;
    checkModel({tag, " R7 after drain"});
    rdCheck(A_FIFO, 8'h00, {tag, " R7 read past end"});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checkModel("R1 reset");
    rdCheck(A_STS, 8'hC0, "R1 R2 reset status encoding");

    // 12-byte command, checks expect, burst, early go and overflow write
    for (int i = 0; i < 12; i++) begin
      pushByte(cmdByte(i, 12, 16));
      if (i == 0) checkModel("R10 R3 first byte");
      if (i == 5) checkModel("R4 length known");
      if (i == 7) begin
        doWr(A_STS, 8'h20);
        checkModel("R9 early go ignored");
      end
      if (i == 10) checkModel("R3 one byte left");
    end
    checkModel("R3 expect cleared");
    pushByte(8'h77);
    checkModel("R9 extra write ignored");
    goAndWait(8'd3, "cmd12");
    checkModel("R4 response burst");
    readResp("cmd12");
    abortCmd("R8 abort from done");

    // oversize length
    for (int i = 0; i < 6; i++) pushByte(cmdByte(i, 70, 0));
    checkModel("R5 oversize error");
    pushByte(8'h11);
    doWr(A_STS, 8'h20);
    checkModel("R5 error ignores write and go");
    abortCmd("R8 abort from error");

    // undersize length
    for (int i = 0; i < 6; i++) pushByte(cmdByte(i, 5, 0));
    checkModel("R5 undersize error");
    abortCmd("R8 abort after undersize");

    // abort mid-receive
    for (int i = 0; i < 4; i++) pushByte(cmdByte(i, 20, 3));
    checkModel("R3 header partial");
    abortCmd("R8 abort mid receive");

    // abort during execution
    for (int i = 0; i < 10; i++) pushByte(cmdByte(i, 10, 40));
    execDelay = 8'd20;
    doWr(A_STS, 8'h20);
    mState = 3;
    checkModel("R6 executing");
    abortCmd("R8 abort during exec");

    // max length with zero latency
    for (int i = 0; i < DEPTH; i++) pushByte(cmdByte(i, DEPTH, 90));
    checkModel("R3 R4 full depth command");
    goAndWait(8'd0, "cmd64");
    readResp("cmd64");
    abortCmd("R8 final abort");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule